// File: doc/BRIEF.md
# GPIO Edge Interrupt Cause Unit

This block watches a bank of general-purpose input pins and records, per pin, that a selected transition has happened. Each pin has its own rising-edge enable and falling-edge enable, so software can pick rising only, falling only, or both. A selected edge sets a sticky cause bit. The bit stays set until software clears it by writing a one to the clear register.

An event mask picks which cause bits drive a single level interrupt output. That output is the OR of all masked causes and may be shared with other sources. Software reads a pre-masked cause view to find the pins that need service. It reads the raw, unmasked causes back through the clear register, then writes the bits it has handled to that same register.

Pins pass through a multi-stage synchroniser before edge detection. Register writes take effect on the clock edge at which they are presented. Reads return data on the clock after the read strobe.

Top module: `gpio_edge_cause`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is 0.
- R2: A 0-to-1 change on a pin whose rising enable bit (word offset 0x00, bit n for pin n) is 1 sets that pin's cause bit. The bit stays set after the pin returns to 0.
- R3: A 1-to-0 change on a pin whose falling enable bit (offset 0x04) is 1 sets that pin's cause bit.
- R4: With both enable bits of a pin set, either transition sets its cause bit.
- R5: A transition on a pin without the matching enable bit leaves that pin's cause bit unchanged.
- R6: Reading offset 0x0C returns the cause bits ANDed with the event mask at offset 0x08.
- R7: Reading offset 0x10 returns the raw, unmasked cause bits.
- R8: Writing offset 0x10 clears every cause bit written as 1 and leaves bits written as 0 unchanged.
- R9: `irq_o` is registered. It equals the OR of (cause AND mask) one clock after that value is present.
- R10: If an edge sets a cause bit in the same cycle that a clear write targets it, the bit ends set. Other bits cleared by the same write still clear.
- R11: A pin change presented before clock edge k sets its cause bit at edge k+2. This covers two synchroniser stages and one compare stage.
- R12: `rdata_o` updates on the edge where `rd_en_i` is high and holds otherwise. Reads of an unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS | Asynchronous pin levels |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Level interrupt, OR of masked causes |

## Verification
The hardest case to reach from the ports is an edge and a clear write landing on the same cycle for the same cause bit. The pin change has to be placed exactly two clocks before the clear write so that the synchroniser delivers the edge in step with it. The stimulus schedules the clear write at that offset. The same write also targets an already-latched bit, which must clear while the colliding bit survives. Random rounds then mix enables, masks, pin patterns and clear masks, and the bench checks every read and the interrupt against a model it updates per pin change.

// File: rtl/gec_pkg.sv
package gec_pkg;
  localparam int OFS_RISE   = 'h00;
  localparam int OFS_FALL   = 'h04;
  localparam int OFS_MASK   = 'h08;
  localparam int OFS_MCAUSE = 'h0C;
  localparam int OFS_CLR    = 'h10;

  typedef enum logic [2:0] {
    SEL_RISE, SEL_FALL, SEL_MASK, SEL_MCAUSE, SEL_CLR, SEL_NONE
  } gec_sel_e;
endpackage

// File: rtl/gec_edge.sv
module gec_edge #(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] rise_o,
  output logic [NPINS-1:0] fall_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [NPINS-1:0] stg [SYNC_STAGES];
  logic [NPINS-1:0] prev_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) stg[g] <= '0;
      else if (g == 0) stg[g] <= pin_i;
      else stg[g] <= stg[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else prev_q <= stg[LAST];
  end

  assign rise_o = stg[LAST] & ~prev_q;
  assign fall_o = ~stg[LAST] & prev_q;
endmodule

// File: rtl/gec_regs.sv
module gec_regs
  import gec_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NPINS-1:0]  cause_i,
  output logic [NPINS-1:0]  rise_en_o,
  output logic [NPINS-1:0]  fall_en_o,
  output logic [NPINS-1:0]  mask_o,
  output logic [NPINS-1:0]  clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  gec_sel_e sel;
  logic [NPINS-1:0] wbits;
  logic [NPINS-1:0] rval;

  assign wbits = wdata_i[NPINS-1:0];

  always_comb begin
    if      (addr_i == ADDR_W'(OFS_RISE))   sel = SEL_RISE;
    else if (addr_i == ADDR_W'(OFS_FALL))   sel = SEL_FALL;
    else if (addr_i == ADDR_W'(OFS_MASK))   sel = SEL_MASK;
    else if (addr_i == ADDR_W'(OFS_MCAUSE)) sel = SEL_MCAUSE;
    else if (addr_i == ADDR_W'(OFS_CLR))    sel = SEL_CLR;
    else                                    sel = SEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_en_o <= '0;
      fall_en_o <= '0;
      mask_o    <= '0;
    end else if (wr_en_i) begin
      if (sel == SEL_RISE) rise_en_o <= wbits;
      if (sel == SEL_FALL) fall_en_o <= wbits;
      if (sel == SEL_MASK) mask_o    <= wbits;
    end
  end

  assign clr_o = (wr_en_i && sel == SEL_CLR) ? wbits : '0;

  always_comb begin
    case (sel)
      SEL_RISE:   rval = rise_en_o;
      SEL_FALL:   rval = fall_en_o;
      SEL_MASK:   rval = mask_o;
      SEL_MCAUSE: rval = cause_i & mask_o;
      SEL_CLR:    rval = cause_i;
      default:    rval = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else if (rd_en_i) rdata_o <= DATA_W'(rval);
  end
endmodule

// File: rtl/gec_cause.sv
module gec_cause #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] set_i,
  input  logic [NPINS-1:0] clr_i,
  input  logic [NPINS-1:0] mask_i,
  output logic [NPINS-1:0] cause_o,
  output logic             irq_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cause_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      cause_o <= (cause_o & ~clr_i) | set_i;
      irq_o   <= |(cause_o & mask_i);
    end
  end
endmodule

// File: rtl/gpio_edge_cause.sv
module gpio_edge_cause #(
  parameter int NPINS       = 32,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [NPINS-1:0] rise, fall, rise_en, fall_en, mask, clr, cause, set_vec;

  gec_edge #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) edge_i (
    .clk(clk), .rst(rst), .pin_i(pin_i), .rise_o(rise), .fall_o(fall)
  );

  gec_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .cause_i(cause),
    .rise_en_o(rise_en), .fall_en_o(fall_en), .mask_o(mask),
    .clr_o(clr), .rdata_o(rdata_o)
  );

  assign set_vec = (rise & rise_en) | (fall & fall_en);

  gec_cause #(.NPINS(NPINS)) cause_i (
    .clk(clk), .rst(rst), .set_i(set_vec), .clr_i(clr),
    .mask_i(mask), .cause_o(cause), .irq_o(irq_o)
  );
endmodule

// File: rtl/gec_checker.sv
module gec_checker #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic [NPINS-1:0]  cause,
  input logic [NPINS-1:0]  mask,
  input logic [NPINS-1:0]  set_vec,
  input logic [NPINS-1:0]  clr,
  input logic [NPINS-1:0]  rise_en,
  input logic [NPINS-1:0]  fall_en
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (irq_o == 1'b0 && cause == '0 && rdata_o == '0));

  assert_irq_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_o == |($past(cause) & $past(mask)));

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((cause & $past(set_vec)) == $past(set_vec)));

  assert_only_enabled_R5: assert property (@(posedge clk) disable iff (rst)
    (set_vec & ~(rise_en | fall_en)) == '0);

  assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((cause & ~$past(cause) & ~$past(set_vec)) == '0));

  assert_clear_only_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(cause) & ~cause & ~$past(clr)) == '0));

  assert_masked_read_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && addr_i == ADDR_W'('h0C)) |=>
      rdata_o == DATA_W'($past(cause) & $past(mask)));
endmodule

bind gpio_edge_cause gec_checker #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .rd_en_i(rd_en_i), .addr_i(addr_i), .rdata_o(rdata_o),
  .irq_o(irq_o), .cause(cause), .mask(mask), .set_vec(set_vec), .clr(clr),
  .rise_en(rise_en), .fall_en(fall_en)
);

// File: tb/gpio_edge_cause_tb.sv
module gpio_edge_cause_tb_top;
  localparam int N = 32;
  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] pin = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;
  int total = 0, bad = 0;
  logic [31:0] m_rise = '0, m_fall = '0, m_mask = '0, m_cause = '0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_edge_cause dut_i (
    .clk(clk), .rst(rst), .pin_i(pin), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  function automatic logic [31:0] edge_model(logic [31:0] o, logic [31:0] n);
    return (n & ~o & m_rise) | (~n & o & m_fall);
  endfunction

  task automatic drive_pins(logic [31:0] n);
    @(negedge clk);
    m_cause = m_cause | edge_model(pin, n);
    pin = n;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_reg(logic [7:0] a, logic [31:0] d);
    wr(a, d);
    if (a == 8'h00) m_rise = d;
    if (a == 8'h04) m_fall = d;
    if (a == 8'h08) m_mask = d;
    if (a == 8'h10) m_cause = m_cause & ~d;
  endtask

  task automatic verify(string tag);
    logic [31:0] v;
    rd(8'h0C, v); check({tag, " R6 masked"}, v, m_cause & m_mask);
    rd(8'h10, v); check({tag, " R7 raw"}, v, m_cause);
    repeat (2) @(negedge clk);
    check({tag, " R9 irq"}, {31'd0, irq}, {31'd0, |(m_cause & m_mask)});
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    for (int a = 0; a <= 16; a += 4) begin
      rd(8'(a), v); check("R1 reg", v, 32'd0);
    end
    // R12 unmapped read and hold
    rd(8'h20, v); check("R12 unmapped", v, 32'd0);
    set_reg(8'h00, 32'h0000_00F1);
    rd(8'h00, v); check("R12 readback", v, 32'h0000_00F1);
    repeat (2) @(negedge clk);
    check("R12 hold", rdata, 32'h0000_00F1);
    // R2 rising, sticky
    set_reg(8'h08, 32'hFFFF_FFFF);
    drive_pins(32'h0000_0003);
    rd(8'h10, v); check("R2 rise", v, 32'h0000_0001);
    drive_pins(32'h0000_0000);
    rd(8'h10, v); check("R2 sticky / R5 no fall en", v, 32'h0000_0001);
    set_reg(8'h10, 32'h0000_0001);
    rd(8'h10, v); check("R8 clear", v, 32'h0);
    // R3 falling
    set_reg(8'h00, 32'h0);
    set_reg(8'h04, 32'h0000_0010);
    drive_pins(32'h0000_0030);
    rd(8'h10, v); check("R3/R5 no rise en", v, 32'h0);
    drive_pins(32'h0000_0000);
    rd(8'h10, v); check("R3 fall", v, 32'h0000_0010);
    // R4 both edges
    set_reg(8'h10, 32'hFFFF_FFFF);
    set_reg(8'h00, 32'h0000_0100);
    set_reg(8'h04, 32'h0000_0100);
    drive_pins(32'h0000_0100);
    rd(8'h10, v); check("R4 both rise", v, 32'h0000_0100);
    set_reg(8'h10, 32'h0000_0100);
    drive_pins(32'h0000_0000);
    rd(8'h10, v); check("R4 both fall", v, 32'h0000_0100);
    // R8 zeros leave bits; R6 mask
    set_reg(8'h08, 32'h0);
    verify("mask0");
    set_reg(8'h10, 32'h0000_00FF);
    rd(8'h10, v); check("R8 zero bits kept", v, 32'h0000_0100);
    set_reg(8'h10, 32'hFFFF_FFFF);
    // R10 and R11: edge at edge k, clear write applied at edge k+2
    set_reg(8'h00, 32'h0000_0003);
    set_reg(8'h04, 32'h0);
    drive_pins(32'h0000_0002);
    @(negedge clk);
    pin = 32'h0000_0003;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h10; wdata = 32'h0000_0003;
    @(negedge clk);
    wr_en = 1'b0;
    m_cause = 32'h0000_0001;
    rd(8'h10, v); check("R10 set wins, R11 timing", v, 32'h0000_0001);
    // R11: cause not yet set one edge early
    set_reg(8'h10, 32'hFFFF_FFFF);
    m_cause = 0;
    @(negedge clk); pin = 32'h0000_0000;
    repeat (4) @(negedge clk);
    @(negedge clk); pin = 32'h0000_0001;
    @(negedge clk); @(negedge clk);
    rd_en = 1'b1; addr = 8'h10;
    @(negedge clk); rd_en = 1'b0;
    check("R11 not before k+2", rdata, 32'h0);
    repeat (3) @(negedge clk);
    m_cause = 32'h0000_0001;
    rd(8'h10, v); check("R11 set after", v, 32'h0000_0001);
    // random rounds
    for (int i = 0; i < 60; i++) begin
      case ($urandom_range(0, 4))
        0: set_reg(8'h00, $urandom);
        1: set_reg(8'h04, $urandom);
        2: set_reg(8'h08, $urandom);
        3: set_reg(8'h10, $urandom);
        default: drive_pins($urandom);
      endcase
      verify("rand R2 R3 R4 R8");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); total++; bad++;
        $display("FAIL watchdog actual=hung expected=done"); end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule